// File: doc/BRIEF.md
# Two-Beat Bus Request Encoder

This block turns one processor request into the request phase of a shared system bus. A request carries a physical address, a transaction kind, a memory-type attribute, a transfer size and a byte mask. The block captures it through a valid/ready handshake and raises a bus request output. One cycle after it samples a grant, it drives two packets on the same address and request pins in two consecutive clocks.

The first packet (A) carries the address and the transaction kind. The address pins hold only the 8-byte-aligned part of the address. For port transactions they hold the port number instead of a memory address. The second packet (B) carries the caching attribute, a length code and the byte mask. Write-back memory traffic always moves a full 64-byte line. Every other kind of traffic is passed through as issued, with the byte mask describing transfers narrower than 8 bytes. Arbitration is reduced to a single grant input. Snoop, response and data phases are outside the block.

Top module: `bus_req_encoder`

## Requirements
- R1: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the packet B cycle. It is high again in the cycle that follows packet B.
- R2: `bus_req` is high from the cycle after acceptance until a grant is sampled. `bus_gnt` is ignored while `bus_req` is low, including in the acceptance cycle itself.
- R3: In the cycle after `bus_gnt` is sampled high with `bus_req` high, `strobe_a` is high. `pin_addr` then holds address bits 35..3 and `pin_req[1:0]` holds the kind: 0 memory read, 1 memory write, 2 port read, 3 port write. `pin_req[4:2]` is zero.
- R4: Packet B appears in the very next cycle on the same pins, with `beat_b` high and `strobe_a` low. `pin_req[2:0]` holds the attribute and `pin_req[4:3]` holds the length code. `pin_addr[7:0]` holds the byte mask and the upper address pins are zero.
- R5: For port kinds (2, 3), packet A's `pin_addr` holds port bits 15..3 zero-extended. Address bits above the 16-bit port field have no effect.
- R6: Attribute codes are 0 uncacheable, 1 write-combining, 4 write-through, 5 write-protect and 6 write-back. Codes 2, 3 and 7 go out as 0, and port kinds always go out as 0.
- R7: A memory request with attribute 6 drives length code 3 (full line) and mask 8'hFF, whatever its size and mask inputs are.
- R8: Any other memory request drives its size code as the length code: 0 up to 8 bytes, 1 for 16, 2 for 32, 3 for 64. With size 0 the input mask is passed unchanged; with any larger size the mask is 8'hFF.
- R9: Port requests drive length code 0 and pass the input mask unchanged, whatever the size input is.
- R10: After reset, and in every cycle that is not a packet beat, `req_ready` is high (when idle), `bus_req`, `strobe_a` and `beat_b` are low, and both pin groups are zero.
- R11: Changes on the request inputs while `req_ready` is low do not alter the packets of the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Encoder can take a request |
| req_addr | input | 36 | Physical address, or port number in bits 15..0 |
| req_kind | input | 2 | 0 mem read, 1 mem write, 2 port read, 3 port write |
| req_mtype | input | 3 | Caching attribute code |
| req_size | input | 2 | 0 up to 8 B, 1 16 B, 2 32 B, 3 64 B |
| req_be | input | 8 | Byte mask for sub-8-byte transfers |
| bus_gnt | input | 1 | Bus grant |
| bus_req | output | 1 | Bus ownership wanted |
| strobe_a | output | 1 | Packet A on the pins |
| beat_b | output | 1 | Packet B on the pins |
| pin_addr | output | 33 | Shared address pins |
| pin_req | output | 5 | Shared request pins |

## Verification
Two events can fall in the same clock: a request is accepted while the grant input is already high. The bench provokes this by raising `bus_gnt` together with `req_valid` and holding both across the acceptance edge. It judges the result by requiring `bus_req` high and `strobe_a` low in the following cycle, with packet A only one cycle later. A second coincidence is `req_valid` kept high through a busy period. In that case packet B must still carry the first request's fields, and the held request must be taken in the first cycle `req_ready` is back.

// File: rtl/bre_pkg.sv
package bre_pkg;

  typedef enum logic [1:0] {
    K_MEM_RD = 2'd0,
    K_MEM_WR = 2'd1,
    K_IO_RD  = 2'd2,
    K_IO_WR  = 2'd3
  } xact_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARB    = 2'd1,
    ST_BEAT_A = 2'd2,
    ST_BEAT_B = 2'd3
  } seq_state_e;

  localparam logic [2:0] MT_UC = 3'd0;
  localparam logic [2:0] MT_WC = 3'd1;
  localparam logic [2:0] MT_WT = 3'd4;
  localparam logic [2:0] MT_WP = 3'd5;
  localparam logic [2:0] MT_WB = 3'd6;

  localparam logic [1:0] LEN_PARTIAL = 2'd0;
  localparam logic [1:0] LEN_LINE    = 2'd3;

  localparam int REQ_W = 5;

  function automatic logic mt_legal(input logic [2:0] mt);
    return (mt == MT_UC) || (mt == MT_WC) || (mt == MT_WT) ||
           (mt == MT_WP) || (mt == MT_WB);
  endfunction

  function automatic logic kind_is_io(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/bre_capture.sv
module bre_capture #(
  parameter int PA_W = 36,
  parameter int BE_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PA_W-1:0] in_addr,
  input  logic [1:0]      in_kind,
  input  logic [2:0]      in_mtype,
  input  logic [1:0]      in_size,
  input  logic [BE_W-1:0] in_be,
  output logic [PA_W-1:0] cap_addr,
  output logic [1:0]      cap_kind,
  output logic [2:0]      cap_mtype,
  output logic [1:0]      cap_size,
  output logic [BE_W-1:0] cap_be
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr  <= '0;
      cap_kind  <= '0;
      cap_mtype <= '0;
      cap_size  <= '0;
      cap_be    <= '0;
    end else if (load) begin
      cap_addr  <= in_addr;
      cap_kind  <= in_kind;
      cap_mtype <= in_mtype;
      cap_size  <= in_size;
      cap_be    <= in_be;
    end
  end

endmodule

// File: rtl/bre_ctrl.sv
module bre_ctrl
  import bre_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic bus_gnt,
  output logic req_ready,
  output logic accept,
  output logic bus_req,
  output logic load_a,
  output logic load_b,
  output logic strobe_a,
  output logic beat_b
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_ARB;
      ST_ARB:    if (bus_gnt)   state_d = ST_BEAT_A;
      ST_BEAT_A:                state_d = ST_BEAT_B;
      ST_BEAT_B:                state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign bus_req   = (state_q == ST_ARB);
  assign load_a    = bus_req && bus_gnt;
  assign load_b    = (state_q == ST_BEAT_A);
  assign strobe_a  = (state_q == ST_BEAT_A);
  assign beat_b    = (state_q == ST_BEAT_B);

endmodule

// File: rtl/bre_pack.sv
module bre_pack
  import bre_pkg::*;
#(
  parameter int PA_W       = 36,
  parameter int ALIGN_BITS = 3,
  parameter int PORT_W     = 16,
  parameter int BE_W       = 8,
  localparam int PIN_AW    = PA_W - ALIGN_BITS
) (
  input  logic [PA_W-1:0]   cap_addr,
  input  logic [1:0]        cap_kind,
  input  logic [2:0]        cap_mtype,
  input  logic [1:0]        cap_size,
  input  logic [BE_W-1:0]   cap_be,
  output logic [PIN_AW-1:0] a_addr,
  output logic [REQ_W-1:0]  a_req,
  output logic [PIN_AW-1:0] b_addr,
  output logic [REQ_W-1:0]  b_req
);

  localparam int PORT_FIELD_W = PORT_W - ALIGN_BITS;
  localparam logic [BE_W-1:0] BE_ALL = '1;

  logic              is_io;
  logic [PIN_AW-1:0] mem_field;
  logic [PIN_AW-1:0] port_field;
  logic [2:0]        attr;
  logic [1:0]        len;
  logic [BE_W-1:0]   mask;
  logic              unused_low;

  assign is_io      = kind_is_io(cap_kind);
  assign mem_field  = cap_addr[PA_W-1:ALIGN_BITS];
  assign unused_low = ^cap_addr[ALIGN_BITS-1:0];

  generate
    if (PORT_FIELD_W > 0) begin : g_port
      assign port_field = {{(PIN_AW-PORT_FIELD_W){1'b0}},
                           cap_addr[PORT_W-1:ALIGN_BITS]};
    end else begin : g_noport
      assign port_field = '0;
    end
  endgenerate

  always_comb begin
    if (is_io || !mt_legal(cap_mtype)) attr = MT_UC;
    else                               attr = cap_mtype;

    if (is_io) begin
      len  = LEN_PARTIAL;
      mask = cap_be;
    end else if (attr == MT_WB) begin
      len  = LEN_LINE;
      mask = BE_ALL;
    end else begin
      len  = cap_size;
      mask = (cap_size == LEN_PARTIAL) ? cap_be : BE_ALL;
    end
  end

  assign a_addr = is_io ? port_field : mem_field;
  assign a_req  = {{(REQ_W-2){1'b0}}, cap_kind};
  assign b_addr = {{(PIN_AW-BE_W){1'b0}}, mask};
  assign b_req  = {len, attr};

endmodule

// File: rtl/bus_req_encoder.sv
module bus_req_encoder
  import bre_pkg::*;
#(
  parameter int PA_W       = 36,
  parameter int ALIGN_BITS = 3,
  parameter int PORT_W     = 16,
  parameter int BE_W       = 8,
  localparam int PIN_AW    = PA_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_mtype,
  input  logic [1:0]        req_size,
  input  logic [BE_W-1:0]   req_be,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              strobe_a,
  output logic              beat_b,
  output logic [PIN_AW-1:0] pin_addr,
  output logic [REQ_W-1:0]  pin_req
);

  logic              accept, load_a, load_b;
  logic [PA_W-1:0]   cap_addr;
  logic [1:0]        cap_kind;
  logic [2:0]        cap_mtype;
  logic [1:0]        cap_size;
  logic [BE_W-1:0]   cap_be;
  logic [PIN_AW-1:0] a_addr, b_addr;
  logic [REQ_W-1:0]  a_req, b_req;

  bre_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .bus_gnt   (bus_gnt),
    .req_ready (req_ready),
    .accept    (accept),
    .bus_req   (bus_req),
    .load_a    (load_a),
    .load_b    (load_b),
    .strobe_a  (strobe_a),
    .beat_b    (beat_b)
  );

  bre_capture #(.PA_W(PA_W), .BE_W(BE_W)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .in_addr   (req_addr),
    .in_kind   (req_kind),
    .in_mtype  (req_mtype),
    .in_size   (req_size),
    .in_be     (req_be),
    .cap_addr  (cap_addr),
    .cap_kind  (cap_kind),
    .cap_mtype (cap_mtype),
    .cap_size  (cap_size),
    .cap_be    (cap_be)
  );

  bre_pack #(
    .PA_W(PA_W), .ALIGN_BITS(ALIGN_BITS), .PORT_W(PORT_W), .BE_W(BE_W)
  ) u_pack (
    .cap_addr  (cap_addr),
    .cap_kind  (cap_kind),
    .cap_mtype (cap_mtype),
    .cap_size  (cap_size),
    .cap_be    (cap_be),
    .a_addr    (a_addr),
    .a_req     (a_req),
    .b_addr    (b_addr),
    .b_req     (b_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_addr <= '0;
      pin_req  <= '0;
    end else if (load_a) begin
      pin_addr <= a_addr;
      pin_req  <= a_req;
    end else if (load_b) begin
      pin_addr <= b_addr;
      pin_req  <= b_req;
    end else begin
      pin_addr <= '0;
      pin_req  <= '0;
    end
  end

endmodule

// File: rtl/bre_checker.sv
module bre_checker #(
  parameter int PIN_AW = 33,
  parameter int BE_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_gnt,
  input logic              bus_req,
  input logic              strobe_a,
  input logic              beat_b,
  input logic [PIN_AW-1:0] pin_addr,
  input logic [4:0]        pin_req
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (bus_req || strobe_a || beat_b) |-> !req_ready);  // R1

  AST_READY_AFTER_B: assert property (@(posedge clk) disable iff (rst)
    beat_b |=> req_ready);  // R1

  AST_ACCEPT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> bus_req);  // R2

  AST_GNT_TO_A: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> (strobe_a && !bus_req));  // R3

  AST_A_KIND_ONLY: assert property (@(posedge clk) disable iff (rst)
    strobe_a |-> (pin_req[4:2] == 3'b000));  // R3

  AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (rst)
    strobe_a |=> (beat_b && !strobe_a));  // R4

  AST_B_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    beat_b |-> (pin_addr[PIN_AW-1:BE_W] == '0));  // R4

  AST_ATTR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    beat_b |-> (pin_req[2:0] inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6}));  // R6

  AST_WB_FULL_LINE: assert property (@(posedge clk) disable iff (rst)
    (beat_b && pin_req[2:0] == 3'd6) |->
      (pin_req[4:3] == 2'd3 && pin_addr[BE_W-1:0] == '1));  // R7

  AST_IDLE_PINS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!strobe_a && !beat_b) |-> (pin_addr == '0 && pin_req == '0));  // R10

endmodule

bind bus_req_encoder bre_checker #(.PIN_AW(PIN_AW), .BE_W(BE_W)) u_bre_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_gnt   (bus_gnt),
  .bus_req   (bus_req),
  .strobe_a  (strobe_a),
  .beat_b    (beat_b),
  .pin_addr  (pin_addr),
  .pin_req   (pin_req)
);

// File: tb/bus_req_encoder_bench.sv
`timescale 1ns/1ps
module bus_req_encoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_mtype = '0;
  logic [1:0]  req_size = '0;
  logic [7:0]  req_be = '0;
  logic        bus_gnt = 1'b0;
  logic        bus_req, strobe_a, beat_b;
  logic [32:0] pin_addr;
  logic [4:0]  pin_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_req_encoder u_bus_req_encoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_mtype(req_mtype),
    .req_size(req_size), .req_be(req_be), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .strobe_a(strobe_a), .beat_b(beat_b),
    .pin_addr(pin_addr), .pin_req(pin_req)
  );

  typedef struct packed {
    logic [35:0] addr;
    logic [1:0]  kind;
    logic [2:0]  mt;
    logic [1:0]  sz;
    logic [7:0]  be;
    logic [32:0] ea;
    logic [4:0]  ear;
    logic [7:0]  ebe;
    logic [4:0]  ebr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{36'h8000010A0, 2'd0, 3'd6, 2'd0, 8'h01, 33'h100000214, 5'h00, 8'hFF, 5'h1E},
    '{36'h0FEE00004, 2'd1, 3'd0, 2'd0, 8'hF0, 33'h01FDC0000, 5'h01, 8'hF0, 5'h00},
    '{36'hABCD103F8, 2'd2, 3'd6, 2'd3, 8'h01, 33'h00000007F, 5'h02, 8'h01, 5'h00},
    '{36'h000000CFC, 2'd3, 3'd1, 2'd2, 8'h0F, 33'h00000019F, 5'h03, 8'h0F, 5'h00},
    '{36'hFFFFFFFC0, 2'd0, 3'd1, 2'd2, 8'h00, 33'h1FFFFFFF8, 5'h00, 8'hFF, 5'h11},
    '{36'h000000008, 2'd1, 3'd3, 2'd0, 8'h3C, 33'h000000001, 5'h01, 8'h3C, 5'h00},
    '{36'h123456780, 2'd1, 3'd5, 2'd1, 8'h00, 33'h02468ACF0, 5'h01, 8'hFF, 5'h0D},
    '{36'h000000040, 2'd0, 3'd4, 2'd3, 8'h00, 33'h000000008, 5'h00, 8'hFF, 5'h1C}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t v);
    req_addr = v.addr; req_kind = v.kind; req_mtype = v.mt;
    req_size = v.sz;   req_be = v.be;
  endtask

  task automatic check_a(input vec_t v);
    check("R3 strobe_a", 64'(strobe_a), 64'd1);
    check(v.kind[1] ? "R5 port pins" : "R3 addr pins", 64'(pin_addr), 64'(v.ea));
    check("R3 kind pins", 64'(pin_req), 64'(v.ear));
    check("R1 ready low A", 64'(req_ready), 64'd0);
  endtask

  task automatic check_b(input vec_t v);
    string lt;
    lt = v.kind[1] ? "R9 len/mask" : (v.mt == 3'd6 ? "R7 len/mask" : "R8 len/mask");
    check("R4 beat_b", 64'({beat_b, strobe_a}), 64'b10);
    check("R6 attr", 64'(pin_req[2:0]), 64'(v.ebr[2:0]));
    check(lt, 64'({pin_req[4:3], pin_addr}), 64'({v.ebr[4:3], 25'd0, v.ebe}));
    check("R1 ready low B", 64'(req_ready), 64'd0);
  endtask

  // One request with dly idle grant cycles; starts and ends at a negedge.
  task automatic run_vec(input vec_t v, input int dly);
    drive(v); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 ready low", 64'(req_ready), 64'd0);
    check("R2 bus_req", 64'(bus_req), 64'd1);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check("R2 wait for grant", 64'({bus_req, strobe_a}), 64'b10);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check_a(v);
    @(negedge clk);
    check_b(v);
    @(negedge clk);
    check("R1 ready back", 64'(req_ready), 64'd1);
    check("R10 idle pins", 64'({pin_req, pin_addr}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 reset ready", 64'(req_ready), 64'd1);
    check("R10 reset flags", 64'({bus_req, strobe_a, beat_b}), 64'd0);
    check("R10 reset pins", 64'({pin_req, pin_addr}), 64'd0);

    // Table walk with varying grant latency
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

    // R2: grant already high in the acceptance cycle is ignored
    drive(VECS[6]); req_valid = 1'b1; bus_gnt = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 gnt at accept ignored", 64'({bus_req, strobe_a}), 64'b10);
    @(negedge clk);
    bus_gnt = 1'b0;
    check_a(VECS[6]);
    @(negedge clk);
    check_b(VECS[6]);
    @(negedge clk);

    // R11: inputs change while busy, valid held; R1: held request taken at first ready
    drive(VECS[0]); req_valid = 1'b1;
    @(negedge clk);
    drive(VECS[3]);
    check("R1 ready low busy", 64'(req_ready), 64'd0);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check("R11 A unchanged", 64'(pin_addr), 64'(VECS[0].ea));
    @(negedge clk);
    check("R11 B unchanged", 64'({pin_req, pin_addr[7:0]}), 64'({VECS[0].ebr, VECS[0].ebe}));
    @(negedge clk);
    check("R1 ready after B", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 held request taken", 64'({req_ready, bus_req}), 64'b01);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check_a(VECS[3]);
    @(negedge clk);
    check_b(VECS[3]);
    @(negedge clk);

    // R2: stray grant while idle has no effect
    bus_gnt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_gnt = 1'b0;
    check("R2 idle grant ignored", 64'({req_ready, bus_req, strobe_a, beat_b}), 64'b1000);
    check("R10 idle pins after grant", 64'({pin_req, pin_addr}), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule